// File: doc/BRIEF.md
# Register-Mapped 16x16 Multiply-Accumulate Unit

This peripheral sits on a plain 16-bit register bus and multiplies two 16-bit operands. It has four operating modes: unsigned product, signed product, unsigned accumulate and signed accumulate. Software does not set the mode in a separate control register. The address that receives the first operand selects it. Writing the second operand runs the operation in that same clock edge.

The bus has one address, one write strobe, write data and a combinational read-data output. Every access is a full 16-bit word. Software reads the 32-bit result as a low word and a high word. A third word holds a sign extension or a carry, depending on the mode. In the multiply modes the visible result is the product register. In the accumulate modes it is the 32-bit accumulator. Each family of modes clears the other family's register when an operation runs.

Top module: `mmio_mac`

## Requirements
- R1: A write to offset 0x130, 0x132, 0x134 or 0x136 loads operand A. The same write sets the mode from address bits 2:1: 0 is unsigned product, 1 is signed product, 2 is unsigned accumulate and 3 is signed accumulate. Reading any of these offsets returns operand A.
- R2: A write to offset 0x138 loads operand B and runs the operation for the current mode. No other write changes the product, the accumulator or the carry. This includes writes to operand A, to the result offsets and to unused offsets.
- R3: In a product mode, the operation stores the 32-bit product and clears the accumulator and the carry.
- R4: In an accumulate mode, the operation adds the product into the 32-bit accumulator and clears the product register. A later switch to a product mode without an operand B write therefore reads a zero result.
- R5: The signed modes sign-extend both operands from bit 15 before multiplying. The unsigned modes zero-extend them.
- R6: Offset 0x13A reads result bits 15:0 and offset 0x13C reads result bits 31:16. The result is the product in the product modes and the accumulator in the accumulate modes.
- R7: Offset 0x13E reads the extension word, which depends on the mode:
  - unsigned product: 0x0000;
  - signed product: 0xFFFF if product bit 31 is set, else 0x0000;
  - unsigned accumulate: the carry out of the last accumulate, as 0x0000 or 0x0001;
  - signed accumulate: 0xFFFF if accumulator bit 31 is set, else 0x0000.
- R8: The new result is readable in the cycle after the operand B write. Operand B writes on consecutive cycles each accumulate, and each one adds to the sum stored at the previous edge.
- R9: A synchronous active-low reset clears both operands, the product, the accumulator and the carry, and sets the mode to unsigned product.
- R10: Offset 0x138 reads back operand B. Unused offsets read 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Word address for the access |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the address, combinational |

## Verification
Two functions can land on the same edge: an accumulate, and the write-back of the accumulate that came just before it. The bench provokes this with operand B writes on back-to-back cycles in the unsigned accumulate mode, with values chosen so that the second sum carries out of bit 31. It judges the result by reading the accumulator words and the carry bit afterwards and comparing them with a model that applies both additions in order. A lost or stale first sum shows up as a wrong low word or a missing carry.

// File: rtl/mmio_mac.sv
module mmio_mac #(
  parameter int W    = 16,
  parameter int AW   = 16,
  parameter int BASE = 'h130
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data
);
  localparam int PW = 2 * W;
  localparam logic [AW-1:0] A_OP1 = AW'(BASE);
  localparam logic [AW-1:0] A_OP2 = AW'(BASE + 8);
  localparam logic [AW-1:0] A_LO  = AW'(BASE + 10);
  localparam logic [AW-1:0] A_HI  = AW'(BASE + 12);
  localparam logic [AW-1:0] A_EXT = AW'(BASE + 14);

  logic [W-1:0]  op1_q, op2_q;
  logic [1:0]    mode_q;
  logic [PW-1:0] prod_q, acc_q;
  logic          carry_q;

  logic op1_hit, op2_wr;
  assign op1_hit = (addr[AW-1:3] == A_OP1[AW-1:3]) && !addr[0];
  assign op2_wr  = wr_en && (addr == A_OP2);

  wire is_signed = mode_q[0];
  wire is_mac    = mode_q[1];

  logic [PW-1:0] ext_a, ext_b, prod_n;
  logic [PW:0]   sum_n;
  assign ext_a  = is_signed ? {{W{wr_data[W-1]}}, wr_data} : {{W{1'b0}}, wr_data};
  assign ext_b  = is_signed ? {{W{op1_q[W-1]}}, op1_q}     : {{W{1'b0}}, op1_q};
  assign prod_n = PW'(ext_a * ext_b);
  assign sum_n  = {1'b0, acc_q} + {1'b0, prod_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op1_q   <= '0;
      op2_q   <= '0;
      mode_q  <= 2'b00;
      prod_q  <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (wr_en) begin
      if (op1_hit) begin
        op1_q  <= wr_data;
        mode_q <= addr[2:1];
      end
      if (op2_wr) begin
        op2_q <= wr_data;
        if (is_mac) begin
          {carry_q, acc_q} <= sum_n;
          prod_q           <= '0;
        end else begin
          prod_q  <= prod_n;
          acc_q   <= '0;
          carry_q <= 1'b0;
        end
      end
    end
  end

  logic [PW-1:0] res;
  logic [W-1:0]  ext_word;
  assign res = is_mac ? acc_q : prod_q;

  always_comb begin
    case (mode_q)
      2'b00:   ext_word = '0;
      2'b10:   ext_word = {{(W-1){1'b0}}, carry_q};
      default: ext_word = {W{res[PW-1]}};
    endcase
  end

  always_comb begin
    if (op1_hit)             rd_data = op1_q;
    else if (addr == A_OP2)  rd_data = op2_q;
    else if (addr == A_LO)   rd_data = res[W-1:0];
    else if (addr == A_HI)   rd_data = res[PW-1:W];
    else if (addr == A_EXT)  rd_data = ext_word;
    else                     rd_data = '0;
  end

  p_op1_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op1_hit) |=> (op1_q == $past(wr_data) && mode_q == $past(addr[2:1])));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op2_wr |=> ($stable(prod_q) && $stable(acc_q) && $stable(carry_q)));

  p_mul_clears_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_wr && !is_mac) |=> (acc_q == '0 && !carry_q));

  p_mac_clears_prod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_wr && is_mac) |=> (prod_q == '0));

  p_carry_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && addr == A_EXT) |-> (rd_data[W-1:1] == '0));
endmodule

// File: tb/mmio_mac_bench.sv
module mmio_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mmio_mac u_mmio_mac (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #2;
    chk(tag, rd_data, exp);
  endtask

  task automatic chk_res(input string tag, input logic [31:0] r, input logic [15:0] e);
    rd_chk({tag, " lo"}, 16'h013A, r[15:0]);
    rd_chk({tag, " hi"}, 16'h013C, r[31:16]);
    rd_chk({tag, " ext"}, 16'h013E, e);
  endtask

  task automatic t_reset;
    chk_res("R9 reset", 32'h0, 16'h0);
    rd_chk("R9 reset op1", 16'h0130, 16'h0);
    rd_chk("R9 reset op2", 16'h0138, 16'h0);
  endtask

  task automatic t_umul;
    wr(16'h0130, 16'hFFFF);
    rd_chk("R1 op1 readback", 16'h0136, 16'hFFFF);
    wr(16'h0138, 16'hFFFF);
    chk_res("R3 R6 umul max", 32'hFFFE_0001, 16'h0000);
    rd_chk("R10 op2 readback", 16'h0138, 16'hFFFF);
  endtask

  task automatic t_smul;
    wr(16'h0132, 16'hFFFF);
    wr(16'h0138, 16'h0002);
    chk_res("R5 R7 smul neg", 32'hFFFF_FFFE, 16'hFFFF);
    wr(16'h0132, 16'h7FFF);
    wr(16'h0138, 16'h7FFF);
    chk_res("R5 R7 smul pos", 32'h3FFF_0001, 16'h0000);
  endtask

  task automatic t_umac_b2b;
    wr(16'h0130, 16'h0001);
    wr(16'h0138, 16'h0001);
    wr(16'h0134, 16'hFFFF);
    chk_res("R3 acc cleared", 32'h0, 16'h0);
    @(negedge clk);
    addr = 16'h0138; wr_data = 16'hFFFF; wr_en = 1'b1;
    @(negedge clk);
    wr_data = 16'hFFFF;
    @(negedge clk);
    wr_en = 1'b0;
    chk_res("R8 R7 umac back-to-back", 32'hFFFC_0002, 16'h0001);
  endtask

  task automatic t_smac;
    wr(16'h0132, 16'h0001);
    wr(16'h0138, 16'h0000);
    wr(16'h0136, 16'hFFFE);
    wr(16'h0138, 16'h0003);
    rd_chk("R8 smac next cycle lo", 16'h013A, 16'hFFFA);
    chk_res("R4 R5 smac neg", 32'hFFFF_FFFA, 16'hFFFF);
    wr(16'h0138, 16'h0005);
    chk_res("R4 smac neg2", 32'hFFFF_FFF0, 16'hFFFF);
    wr(16'h0136, 16'h0004);
    wr(16'h0138, 16'h0005);
    chk_res("R4 R7 smac pos", 32'h0000_0004, 16'h0000);
  endtask

  task automatic t_switch;
    wr(16'h0130, 16'h0003);
    chk_res("R4 product cleared by mac", 32'h0, 16'h0);
    wr(16'h0138, 16'h0007);
    chk_res("R3 umul after mac", 32'h0000_0015, 16'h0);
    wr(16'h0134, 16'h0002);
    chk_res("R3 acc cleared by mul", 32'h0, 16'h0);
  endtask

  task automatic t_ignore;
    wr(16'h0130, 16'h0010);
    wr(16'h0138, 16'h0010);
    wr(16'h013A, 16'h1234);
    wr(16'h013E, 16'hFFFF);
    wr(16'h0140, 16'h5555);
    wr(16'h0130, 16'h0020);
    chk_res("R2 no trigger", 32'h0000_0100, 16'h0);
    rd_chk("R10 unused read", 16'h0140, 16'h0);
    rd_chk("R2 op2 unchanged", 16'h0138, 16'h0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_umul();
    t_smul();
    t_umac_b2b();
    t_smac();
    t_switch();
    t_ignore();
    wr(16'h0136, 16'h1111);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule